// File: doc/BRIEF.md
# Multi-Mode Operand Locator

This block turns an instruction's addressing-mode code, its address/immediate field and its register-select field into an operand value and an effective address. It holds a small general register file and reaches data memory through a request/ready read port. Nine modes are handled: implied, immediate, direct, indirect, register-direct, register-indirect, post-increment, pre-decrement and indexed. It issues whatever memory reads the mode needs, one after another, and writes the stepped base register back for the two auto-stepping modes.

A request is presented with `start` while the unit is idle. When the operand is known, `done` pulses for one cycle with `operand` and `eff_addr` valid. A separate write port loads the register file, for example from an execution stage writing back results. Arithmetic on the operand and instruction fetch belong to other blocks.

Top module: `operand_locator`

## Requirements
- R1: After a synchronous active-low reset, every register holds 0 and `busy`, `done`, `mem_req`, `operand` and `eff_addr` are 0.
- R2: Mode code 0 (implied), and every unused code 9 to 15, gives operand 0 and address 0 with no memory read, and `done` rises in the cycle after the request is accepted.
- R3: Mode code 1 (immediate) gives the field as operand, address 0 and no memory read, with `done` in the cycle after acceptance.
- R4: Mode code 2 (direct) makes one memory read at the field; the read data is the operand and the field is the address.
- R5: Mode code 3 (indirect) reads memory at the field, uses the returned word as the effective address and reads again there; the second word is the operand. Exactly two reads are made.
- R6: Mode code 4 (register-direct) gives the selected register as operand, address 0 and no memory read; a write on the register write port is visible from the next cycle.
- R7: Mode code 5 (register-indirect) uses the selected register as address, makes one read, and leaves the register unchanged.
- R8: Mode code 6 (post-increment) uses the selected register as address, makes one read, and leaves the register one higher, wrapping 0xFFFF to 0x0000.
- R9: Mode code 7 (pre-decrement) first subtracts one from the selected register (0x0000 wraps to 0xFFFF), uses that value as address, makes one read, and leaves the register at that value.
- R10: Mode code 8 (indexed) uses field plus selected register, modulo 2^16, as address and makes one read.
- R11: `mem_req` with `mem_addr` stays stable until `mem_ready` is seen high at a clock edge; `mem_rdata` is taken in that same cycle, and any number of wait cycles is allowed.
- R12: `done` is high for exactly one cycle per accepted request, `busy` is high from acceptance until `done`, and a `start` while busy is ignored entirely (no extra done, no register step).
- R13: When a post-increment or pre-decrement write-back and a write-port write target the same register in the same cycle, the write-back value is kept; a write-port write to another register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing-mode code |
| field | input | 16 | Address or immediate field of the instruction |
| sel | input | 3 | Register-select field |
| busy | output | 1 | A request is being worked on |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 16 | Resolved operand value |
| eff_addr | output | 16 | Effective address (0 for modes without one) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 16 | Memory read data |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 16 | Register file write data |

## Verification
The base-register step of the post-increment and pre-decrement modes happens on the edge that accepts the request, which is also the edge on which an outside write to the register file can land. The bench drives a post-increment request and a write-port write into the same register in one cycle, then reads that register back through register-direct mode and expects the stepped value, not the written one. It repeats the pairing with the write aimed at a different register and expects both updates to survive.

// File: rtl/ea_pkg.sv
// Package: shared mode codes and decoded control word for the operand locator.
// Assumes a 4-bit mode code; codes above 8 are treated as implied.
package ea_pkg;
    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPLIED  = 4'd0,
        AM_IMMED    = 4'd1,
        AM_DIRECT   = 4'd2,
        AM_INDIRECT = 4'd3,
        AM_REG      = 4'd4,
        AM_REG_IND  = 4'd5,
        AM_POST_INC = 4'd6,
        AM_PRE_DEC  = 4'd7,
        AM_INDEXED  = 4'd8
    } am_t;

    typedef struct packed {
        logic use_mem;       // at least one memory read
        logic two_reads;     // pointer read before operand read
        logic addr_from_reg; // base address is the selected register
        logic add_field;     // address is field + register
        logic step_up;       // register += 1 after use
        logic step_down;     // register -= 1 before use
        logic op_from_field; // operand is the field itself
        logic op_from_reg;   // operand is the register itself
    } am_ctrl_t;
endpackage

// File: rtl/ea_mode_decode.sv
// Module: ea_mode_decode
// Turns the mode code into a control word. Purely combinational.
// Assumes unknown codes behave as implied (all controls low).
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output am_ctrl_t          ctrl
);
    // Map each mode code to its control word.
    always_comb begin
        ctrl = '0;
        case (mode)
            AM_IMMED:    ctrl.op_from_field = 1'b1;
            AM_DIRECT:   ctrl.use_mem = 1'b1;
            AM_INDIRECT: begin
                ctrl.use_mem   = 1'b1;
                ctrl.two_reads = 1'b1;
            end
            AM_REG:      ctrl.op_from_reg = 1'b1;
            AM_REG_IND:  begin
                ctrl.use_mem       = 1'b1;
                ctrl.addr_from_reg = 1'b1;
            end
            AM_POST_INC: begin
                ctrl.use_mem       = 1'b1;
                ctrl.addr_from_reg = 1'b1;
                ctrl.step_up       = 1'b1;
            end
            AM_PRE_DEC:  begin
                ctrl.use_mem       = 1'b1;
                ctrl.addr_from_reg = 1'b1;
                ctrl.step_down     = 1'b1;
            end
            AM_INDEXED:  begin
                ctrl.use_mem   = 1'b1;
                ctrl.add_field = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/ea_regfile.sv
// Module: ea_regfile
// General register file with one combinational read port and two write
// ports: the auto-step write-back and an outside write port.
// Assumes write-back has priority when both target the same register.
module ea_regfile #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned WORD_W   = 16,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [SEL_W-1:0]  ext_idx,
    input  logic [WORD_W-1:0] ext_val,
    input  logic              wb_we,
    input  logic [SEL_W-1:0]  wb_idx,
    input  logic [WORD_W-1:0] wb_val,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_val
);
    logic [WORD_W-1:0] regs [NUM_REGS];

    // Register storage: reset to zero, write-back wins over outside write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wb_we && wb_idx == SEL_W'(i))
                regs[i] <= wb_val;
            else if (ext_we && ext_idx == SEL_W'(i))
                regs[i] <= ext_val;
        end
    end

    // Read port: current content of the selected register.
    assign rd_val = regs[rd_idx];

    // R13
    wb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |=> regs[$past(wb_idx)] == $past(wb_val));

    // R6
    ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_we && !(wb_we && wb_idx == ext_idx)) |=>
            regs[$past(ext_idx)] == $past(ext_val));
endmodule

// File: rtl/ea_seq.sv
// Module: ea_seq
// Sequencer: accepts a request when idle, issues zero, one or two memory
// reads through a request/ready handshake, and registers the results.
// Assumes read data is valid in the cycle mem_ready is high.
module ea_seq #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              use_mem,
    input  logic              two_reads,
    input  logic [WORD_W-1:0] first_addr,
    input  logic [WORD_W-1:0] direct_operand,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] eff_addr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr
);
    typedef enum logic [1:0] {S_IDLE, S_PTR, S_DATA} seq_state_t;

    seq_state_t        state;
    logic [WORD_W-1:0] addr_q;

    assign accept   = start && (state == S_IDLE);
    assign busy     = (state != S_IDLE);
    assign mem_req  = (state != S_IDLE);
    assign mem_addr = addr_q;

    // State walk and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            done     <= 1'b0;
            operand  <= '0;
            eff_addr <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (use_mem) begin
                            addr_q <= first_addr;
                            state  <= two_reads ? S_PTR : S_DATA;
                        end else begin
                            operand  <= direct_operand;
                            eff_addr <= '0;
                            done     <= 1'b1;
                        end
                    end
                end
                S_PTR: begin
                    if (mem_ready) begin
                        addr_q <= mem_rdata;
                        state  <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (mem_ready) begin
                        operand  <= mem_rdata;
                        eff_addr <= addr_q;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R5
    ptr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR && mem_ready) |=> (mem_req && mem_addr == $past(mem_rdata)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/operand_locator.sv
// Module: operand_locator (top)
// Resolves an operand and effective address from a mode code, an
// address/immediate field and a register select. Holds the register file,
// the mode decoder and the read sequencer; computes the first address and
// the auto-step write-back value.
// Assumes addresses and data share one word width.
module operand_locator
    import ea_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned WORD_W   = 16,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [WORD_W-1:0] field,
    input  logic [SEL_W-1:0]  sel,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] eff_addr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              rf_we,
    input  logic [SEL_W-1:0]  rf_waddr,
    input  logic [WORD_W-1:0] rf_wdata
);
    am_ctrl_t          ctrl;
    logic [WORD_W-1:0] reg_val;
    logic [WORD_W-1:0] first_addr;
    logic [WORD_W-1:0] direct_operand;
    logic [WORD_W-1:0] wb_val;
    logic              wb_we;
    logic              accept;

    ea_mode_decode u_dec (
        .mode (mode),
        .ctrl (ctrl)
    );

    ea_regfile #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_we  (rf_we),
        .ext_idx (rf_waddr),
        .ext_val (rf_wdata),
        .wb_we   (wb_we),
        .wb_idx  (sel),
        .wb_val  (wb_val),
        .rd_idx  (sel),
        .rd_val  (reg_val)
    );

    // First memory address for the selected mode.
    always_comb begin
        if (ctrl.step_down)
            first_addr = reg_val - WORD_W'(1);
        else if (ctrl.addr_from_reg)
            first_addr = reg_val;
        else if (ctrl.add_field)
            first_addr = field + reg_val;
        else
            first_addr = field;
    end

    // Operand for modes that need no memory read.
    always_comb begin
        if (ctrl.op_from_field)
            direct_operand = field;
        else if (ctrl.op_from_reg)
            direct_operand = reg_val;
        else
            direct_operand = '0;
    end

    // Auto-step write-back, applied on the accepting edge.
    assign wb_we  = accept && (ctrl.step_up || ctrl.step_down);
    assign wb_val = ctrl.step_up ? (reg_val + WORD_W'(1)) : (reg_val - WORD_W'(1));

    ea_seq #(.WORD_W(WORD_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .use_mem        (ctrl.use_mem),
        .two_reads      (ctrl.two_reads),
        .first_addr     (first_addr),
        .direct_operand (direct_operand),
        .mem_ready      (mem_ready),
        .mem_rdata      (mem_rdata),
        .accept         (accept),
        .busy           (busy),
        .done           (done),
        .operand        (operand),
        .eff_addr       (eff_addr),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr)
    );

    // R2
    nomem_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !ctrl.use_mem) |=> (done && !mem_req));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));
endmodule

// File: tb/tb_operand_locator.sv
`timescale 1ns/1ps
module tb_operand_locator;
    localparam logic [3:0] M_IMP = 4'd0, M_IMM = 4'd1, M_DIR = 4'd2, M_IND = 4'd3,
                           M_REG = 4'd4, M_RIN = 4'd5, M_INC = 4'd6, M_DEC = 4'd7,
                           M_IDX = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] field = '0;
    logic [2:0]  sel = '0;
    logic        busy, done, mem_req;
    logic [15:0] operand, eff_addr, mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        rf_we = 1'b0;
    logic [2:0]  rf_waddr = '0;
    logic [15:0] rf_wdata = '0;

    int n_checks = 0, n_fail = 0;
    int lat = 0, wait_cnt = 0;
    int n_reads = 0, n_done = 0, hs_bad = 0;
    bit summary_done = 0;
    logic        prev_req = 0, prev_ready = 0;
    logic [15:0] prev_addr = '0;

    operand_locator dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field), .sel(sel),
        .busy(busy), .done(done), .operand(operand), .eff_addr(eff_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] mf(input logic [15:0] a);
        return (a ^ 16'hA5C3) + 16'h0137;
    endfunction

    // Memory model: answers after lat wait cycles, one word per request.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ready <= 1'b1;
                mem_rdata <= mf(mem_addr);
            end else
                wait_cnt <= wait_cnt + 1;
        end else
            wait_cnt <= 0;
    end

    // Monitors: read count, done count, handshake stability.
    always @(posedge clk) begin
        if (mem_req && mem_ready) n_reads++;
        if (done) n_done++;
        if (rst_n && prev_req && !prev_ready && (!mem_req || mem_addr != prev_addr)) hs_bad++;
        prev_req = mem_req; prev_ready = mem_ready; prev_addr = mem_addr;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        end
    endtask

    task automatic wr_reg(input logic [2:0] r, input logic [15:0] v);
        @(negedge clk); rf_we = 1; rf_waddr = r; rf_wdata = v;
        @(negedge clk); rf_we = 0;
    endtask

    task automatic do_req(input logic [3:0] m, input logic [15:0] f, input logic [2:0] s,
                          output logic [15:0] op, output logic [15:0] ea, output int cyc);
        @(negedge clk); start = 1; mode = m; field = f; sel = s; n_reads = 0;
        @(negedge clk); start = 0; cyc = 0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        op = operand; ea = eff_addr;
        @(negedge clk);
        chk("R12 done drops after one cycle", {15'd0, done}, 16'd0);
    endtask

    function automatic logic [15:0] rd_expect_dummy(input logic [15:0] v);
        return v;
    endfunction

    task automatic read_reg(input logic [2:0] r, output logic [15:0] v);
        logic [15:0] e; int c;
        do_req(M_REG, 16'h0, r, v, e, c);
    endtask

    task automatic t_reset();
        chk("R1 busy", {15'd0, busy}, 0);
        chk("R1 done", {15'd0, done}, 0);
        chk("R1 mem_req", {15'd0, mem_req}, 0);
        chk("R1 operand", operand, 0);
        chk("R1 eff_addr", eff_addr, 0);
        for (int r = 0; r < 8; r++) begin
            logic [15:0] v;
            read_reg(r[2:0], v);
            chk("R1 register zero", v, 0);
        end
    endtask

    task automatic t_nomem();
        logic [15:0] op, ea; int c;
        do_req(M_IMP, 16'h1234, 3'd1, op, ea, c);
        chk("R2 implied operand", op, 0); chk("R2 implied ea", ea, 0);
        chk("R2 implied reads", 16'(n_reads), 0); chk("R2 implied latency", 16'(c), 0);
        do_req(4'd13, 16'h5555, 3'd1, op, ea, c);
        chk("R2 unused code operand", op, 0); chk("R2 unused code reads", 16'(n_reads), 0);
        do_req(M_IMM, 16'hBEEF, 3'd1, op, ea, c);
        chk("R3 immediate operand", op, 16'hBEEF); chk("R3 immediate ea", ea, 0);
        chk("R3 immediate reads", 16'(n_reads), 0); chk("R3 immediate latency", 16'(c), 0);
        do_req(M_REG, 16'h7777, 3'd1, op, ea, c);
        chk("R6 register operand", op, 16'h1000); chk("R6 register ea", ea, 0);
        chk("R6 register reads", 16'(n_reads), 0);
    endtask

    task automatic t_direct();
        logic [15:0] op, ea; int c;
        lat = 0;
        do_req(M_DIR, 16'h0040, 3'd0, op, ea, c);
        chk("R4 direct operand", op, mf(16'h0040)); chk("R4 direct ea", ea, 16'h0040);
        chk("R4 direct reads", 16'(n_reads), 1);
    endtask

    task automatic t_indirect();
        logic [15:0] op, ea; int c;
        lat = 2;
        do_req(M_IND, 16'h0100, 3'd0, op, ea, c);
        chk("R5 indirect ea", ea, mf(16'h0100));
        chk("R5 indirect operand", op, mf(mf(16'h0100)));
        chk("R5 indirect reads", 16'(n_reads), 2);
        lat = 0;
    endtask

    task automatic t_regind();
        logic [15:0] op, ea, v; int c;
        do_req(M_RIN, 16'h0, 3'd1, op, ea, c);
        chk("R7 reg-indirect ea", ea, 16'h1000); chk("R7 reg-indirect operand", op, mf(16'h1000));
        chk("R7 reg-indirect reads", 16'(n_reads), 1);
        read_reg(3'd1, v); chk("R7 register unchanged", v, 16'h1000);
    endtask

    task automatic t_postinc();
        logic [15:0] op, ea, v; int c;
        do_req(M_INC, 16'h0, 3'd2, op, ea, c);
        chk("R8 post-inc ea", ea, 16'hFFFF); chk("R8 post-inc operand", op, mf(16'hFFFF));
        read_reg(3'd2, v); chk("R8 register wraps to 0", v, 16'h0000);
        do_req(M_INC, 16'h0, 3'd2, op, ea, c);
        chk("R8 second ea", ea, 16'h0000);
        read_reg(3'd2, v); chk("R8 register now 1", v, 16'h0001);
    endtask

    task automatic t_predec();
        logic [15:0] op, ea, v; int c;
        do_req(M_DEC, 16'h0, 3'd3, op, ea, c);
        chk("R9 pre-dec ea", ea, 16'hFFFF); chk("R9 pre-dec operand", op, mf(16'hFFFF));
        read_reg(3'd3, v); chk("R9 register wraps to FFFF", v, 16'hFFFF);
        do_req(M_DEC, 16'h0, 3'd3, op, ea, c);
        chk("R9 second ea", ea, 16'hFFFE);
    endtask

    task automatic t_indexed();
        logic [15:0] op, ea; int c;
        do_req(M_IDX, 16'h0100, 3'd4, op, ea, c);
        chk("R10 indexed ea", ea, 16'h0120); chk("R10 indexed operand", op, mf(16'h0120));
        chk("R10 indexed reads", 16'(n_reads), 1);
        do_req(M_IDX, 16'h1800, 3'd6, op, ea, c);
        chk("R10 indexed wrap ea", ea, 16'h0800);
    endtask

    task automatic t_handshake();
        logic [15:0] op, ea; int c;
        lat = 5; hs_bad = 0;
        do_req(M_DIR, 16'h0222, 3'd0, op, ea, c);
        chk("R11 slow direct operand", op, mf(16'h0222));
        chk("R11 waits stretch latency", 16'(c >= 6), 1);
        do_req(M_IND, 16'h0333, 3'd0, op, ea, c);
        chk("R11 slow indirect operand", op, mf(mf(16'h0333)));
        chk("R11 request held stable", 16'(hs_bad), 0);
        lat = 0;
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v; int c;
        lat = 3;
        @(negedge clk); start = 1; mode = M_IND; field = 16'h0404; sel = 3'd0;
        @(negedge clk); start = 0;
        chk("R12 busy after accept", {15'd0, busy}, 1);
        @(negedge clk); n_done = 0; start = 1; mode = M_INC; sel = 3'd5; field = 16'h0;
        @(negedge clk); start = 0;
        c = 0;
        while (!done && c < 200) begin @(negedge clk); c++; end
        chk("R12 first request result", operand, mf(mf(16'h0404)));
        repeat (20) @(negedge clk);
        chk("R12 single done", 16'(n_done), 1);
        lat = 0;
        read_reg(3'd5, v); chk("R12 ignored request left register", v, 16'h0777);
    endtask

    task automatic t_collision();
        logic [15:0] v; int c;
        @(negedge clk); start = 1; mode = M_INC; sel = 3'd1; field = 0;
        rf_we = 1; rf_waddr = 3'd1; rf_wdata = 16'h1234;
        @(negedge clk); start = 0; rf_we = 0; c = 0;
        while (!done && c < 200) begin @(negedge clk); c++; end
        @(negedge clk);
        read_reg(3'd1, v); chk("R13 write-back wins same register", v, 16'h1001);
        @(negedge clk); start = 1; mode = M_INC; sel = 3'd1; field = 0;
        rf_we = 1; rf_waddr = 3'd7; rf_wdata = 16'hCAFE;
        @(negedge clk); start = 0; rf_we = 0; c = 0;
        while (!done && c < 200) begin @(negedge clk); c++; end
        @(negedge clk);
        read_reg(3'd1, v); chk("R13 stepped register", v, 16'h1002);
        read_reg(3'd7, v); chk("R13 other register written", v, 16'hCAFE);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        wr_reg(3'd1, 16'h1000); wr_reg(3'd2, 16'hFFFF); wr_reg(3'd3, 16'h0000);
        wr_reg(3'd4, 16'h0020); wr_reg(3'd5, 16'h0777); wr_reg(3'd6, 16'hF000);
        t_nomem();
        t_direct();
        t_indirect();
        t_regind();
        t_postinc();
        t_predec();
        t_indexed();
        t_handshake();
        t_busy_ignore();
        t_collision();
        report();
        $finish;
    end
endmodule